// File: doc/BRIEF.md
# Rotating-Start Unit-Element Selector

This block drives the switch enables of a thermometer-coded DAC built from N = 2^NBITS equal unit elements. For a requested level k it turns on exactly k elements that sit next to each other. The elements are treated as a ring, and the run of enabled elements can begin at any of P_ITER evenly spaced start points. Moving the start point between samples spreads each element's mismatch evenly over the repeated samples of one level. The start points lie Q = N / P_ITER elements apart. P_ITER is a power of two, at least 2, that divides N. A run that passes the top element continues from element 0.

The block has two ways of working. In single-sample use, each `step` pulse loads one mask directly from `code_in` and `iter_in`. In sweep use, a `start` pulse latches a first level. After that, each `step` presents that level at start points 0 to P_ITER-1, then moves on to the next level. The sweep ends after the sample for level N at the last start point. While the sweep runs, `busy` is high. When it ends, `done` goes high.

Top module: `rot_sel_ctrl`

## Requirements
- R1: After reset, `mask_out`, `code_out`, `iter_out`, `busy` and `done` are all zero.
- R2: A `step` pulse while `busy` is low and `start` is low updates the outputs at that clock edge. `mask_out` bit (j*Q + e) mod N is set for every e in 0..k-1, and every other bit is clear. Here k is the level from `code_in`, j is `iter_in`, and bit 0 is element 0. `code_out` becomes k and `iter_out` becomes j.
- R3: Level 0 gives an all-zero mask at every start point. A `code_in` value of N or above is clamped to N and gives an all-ones mask.
- R4: `mask_out`, `code_out` and `iter_out` change only at an edge where `step` is sampled high and no sweep is being launched.
- R5: `start` sampled high while `busy` is low raises `busy` at that edge and clears `done`. It latches clamp(`code_in`) as the first level, with start point 0. The mask does not change at that edge, even if `step` is also high.
- R6: While `busy` is high, each `step` outputs the mask for the current level and start point, then advances. The start point counts 0..P_ITER-1. After P_ITER-1 the level increases by one and the start point returns to 0.
- R7: The `step` that outputs level N at start point P_ITER-1 ends the sweep at the same edge: `busy` falls and `done` rises.
- R8: While `busy` is high, `code_in`, `iter_in` and `start` have no effect on the sweep.
- R9: `done` stays high until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a sweep (ignored while busy) |
| step | input | 1 | Sample-advance strobe |
| code_in | input | NBITS+1 | Level for single samples / first level of a sweep |
| iter_in | input | log2(P_ITER) | Start-point index for single samples |
| mask_out | output | 2^NBITS | Registered element enables |
| code_out | output | NBITS+1 | Level of the current mask |
| iter_out | output | log2(P_ITER) | Start-point index of the current mask |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sweep completed |

## Verification
The bench targets runs that wrap past the top element. A design with a plain shift instead of a rotate would drop the bits that should reappear at element 0. It also applies level 0 and level N at nonzero start points, where an off-by-one thermometer or a missing clamp would leave one bit wrong or give an empty mask. Sweeps are checked step by step across a level boundary and at the final sample. A wrong carry shows up as a skipped or repeated start point, and a wrong end test shows up as `done` arriving one sample early or late. The bench also toggles `code_in`, `iter_in` and `start` in the middle of a sweep, which exposes a design that lets idle-mode inputs leak into the sequence.

// File: rtl/rot_sel_ctrl.sv
module rot_sel_ctrl #(
  parameter int NBITS  = 9,
  parameter int P_ITER = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic                        step,
  input  logic [NBITS:0]              code_in,
  input  logic [$clog2(P_ITER)-1:0]   iter_in,
  output logic [(1<<NBITS)-1:0]       mask_out,
  output logic [NBITS:0]              code_out,
  output logic [$clog2(P_ITER)-1:0]   iter_out,
  output logic                        busy,
  output logic                        done
);
  localparam int N   = 1 << NBITS;
  localparam int Q   = N / P_ITER;
  localparam int QSH = $clog2(Q);
  localparam int PW  = $clog2(P_ITER);
  localparam int CW  = NBITS + 1;
  localparam logic [CW-1:0] FULL  = CW'(N);
  localparam logic [PW-1:0] LASTD = PW'(P_ITER - 1);

  logic [CW-1:0]    run_k, code_q, clamp_k, sel_k;
  logic [PW-1:0]    run_d, iter_q, sel_d;
  logic [N-1:0]     mask_q, thermo, rot;
  logic [2*N-1:0]   dbl;
  logic [NBITS-1:0] offs;
  logic             busy_q, done_q, launch;

  assign clamp_k = (code_in > FULL) ? FULL : code_in;
  assign sel_k   = busy_q ? run_k : clamp_k;
  assign sel_d   = busy_q ? run_d : iter_in;
  assign offs    = NBITS'(sel_d) << QSH;
  assign launch  = start && !busy_q;

  always_comb begin
    for (int i = 0; i < N; i++) thermo[i] = (32'(sel_k) > i);
  end

  assign dbl = {thermo, thermo} << offs;
  assign rot = dbl[2*N-1:N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      code_q <= '0;
      iter_q <= '0;
      run_k  <= '0;
      run_d  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (launch) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      run_k  <= clamp_k;
      run_d  <= '0;
    end else if (step) begin
      mask_q <= rot;
      code_q <= sel_k;
      iter_q <= sel_d;
      if (busy_q) begin
        if (run_d == LASTD) begin
          run_d <= '0;
          if (run_k == FULL) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            run_k <= run_k + 1'b1;
          end
        end else begin
          run_d <= run_d + 1'b1;
        end
      end
    end
  end

  assign mask_out = mask_q;
  assign code_out = code_q;
  assign iter_out = iter_q;
  assign busy     = busy_q;
  assign done     = done_q;

  // R2/R3: enabled element count equals the reported level
  assert_popcount_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mask_q) == int'(code_q));

  // R2: the run begins at the rotated start element
  assert_start_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q != '0) |-> mask_q[int'(iter_q) * Q]);

  // R4: outputs hold without a step strobe
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(mask_q) && $stable(code_q) && $stable(iter_q));

  // R7: completion only after the last sample of the full level
  assert_done_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> (code_q == FULL) && (iter_q == LASTD) && !busy_q);

  // R9: busy and done never overlap
  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q));
endmodule

// File: tb/rot_sel_ctrl_bench.sv
module rot_sel_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 6;
  localparam int P  = 8;
  localparam int N  = 1 << NB;
  localparam int Q  = N / P;
  localparam int PW = $clog2(P);

  logic clk = 0, rst_n = 0, start = 0, step = 0;
  logic [NB:0]   code_in = '0;
  logic [PW-1:0] iter_in = '0;
  logic [N-1:0]  mask_out;
  logic [NB:0]   code_out;
  logic [PW-1:0] iter_out;
  logic busy, done;
  int checks = 0, errors = 0;
  bit finished = 0;

  rot_sel_ctrl #(.NBITS(NB), .P_ITER(P)) u_rot_sel_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step),
    .code_in(code_in), .iter_in(iter_in), .mask_out(mask_out),
    .code_out(code_out), .iter_out(iter_out), .busy(busy), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [N-1:0] exp_mask(int k, int j);
    logic [N-1:0] m = '0;
    if (k > N) k = N;
    for (int e = 0; e < k; e++) m[(j*Q + e) % N] = 1'b1;
    return m;
  endfunction

  task automatic chk(string req, logic [N-1:0] am, logic [N-1:0] em,
                     int ak, int ek, int ai, int ei, bit ab, bit eb, bit ad, bit ed);
    checks++;
    if (am !== em || ak != ek || ai != ei || ab !== eb || ad !== ed) begin
      errors++;
      $display("FAIL %s: mask=%h code=%0d iter=%0d busy=%b done=%b, expected mask=%h code=%0d iter=%0d busy=%b done=%b",
               req, am, ak, ai, ab, ad, em, ek, ei, eb, ed);
    end
  endtask

  task automatic pulse(bit s, bit t);
    @(negedge clk); start = s; step = t;
    @(negedge clk); start = 0; step = 0;
  endtask

  task automatic single(int k, int j, string req);
    code_in = (NB+1)'(k); iter_in = PW'(j);
    pulse(0, 1);
    chk(req, mask_out, exp_mask(k, j), code_out, (k > N) ? N : k, iter_out, j,
        busy, 0, done, done);
  endtask

  task automatic sweep(int k0, bit disturb, string req);
    int ek = (k0 > N) ? N : k0;
    int ed = 0;
    logic [N-1:0] held;
    code_in = (NB+1)'(k0);
    held = mask_out;
    pulse(1, 1);
    chk("R5", mask_out, held, code_out, code_out, iter_out, iter_out, busy, 1, done, 0);
    forever begin
      if (disturb) begin
        code_in = (NB+1)'($urandom_range(0, N)); iter_in = PW'($urandom);
        if ($urandom_range(0, 3) == 0) begin
          pulse(1, 0);
          chk("R8", mask_out, mask_out, code_out, code_out, iter_out, iter_out, busy, 1, done, 0);
        end
      end
      pulse(0, 1);
      begin
        bit last = (ek == N) && (ed == P-1);
        chk(last ? "R7" : req, mask_out, exp_mask(ek, ed), code_out, ek, iter_out, ed,
            busy, !last, done, last);
        if (last) break;
      end
      if (ed == P-1) begin ed = 0; ek++; end else ed++;
    end
  endtask

  initial begin
    void'($urandom(32'd4177));
    repeat (3) @(negedge clk);
    chk("R1", mask_out, '0, code_out, 0, iter_out, 0, busy, 0, done, 0);
    rst_n = 1;
    @(negedge clk);
    // R4: no step, inputs wiggle, nothing moves
    code_in = 7'd5; iter_in = 3'd2;
    repeat (3) @(negedge clk);
    chk("R4", mask_out, '0, code_out, 0, iter_out, 0, busy, 0, done, 0);
    // R2 directed wrap cases
    single(10, P-1, "R2");
    single(1, 3, "R2");
    single(N-1, 5, "R2");
    // R3 extremes
    for (int j = 0; j < P; j += 3) single(0, j, "R3");
    single(N, 4, "R3");
    single(N+1, 6, "R3");
    single(2*N-1, 1, "R3");
    // R2 random single samples
    for (int i = 0; i < 200; i++) single($urandom_range(0, N), $urandom_range(0, P-1), "R2");
    // R6/R7 sweep near top with disturbance (R8)
    sweep(N-3, 1, "R8");
    @(negedge clk);
    chk("R9", mask_out, exp_mask(N, P-1), code_out, N, iter_out, P-1, busy, 0, done, 1);
    single(7, 2, "R9");
    chk("R9", mask_out, exp_mask(7, 2), code_out, 7, iter_out, 2, busy, 0, done, 1);
    // full sweep from zero
    sweep(0, 0, "R6");
    // clamped start level
    sweep(N+5, 0, "R6");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule